// File: doc/BRIEF.md
# Banked Register File Addressing

This block is the data-memory subsystem of a small 8-bit controller core. It takes a 6-bit register address from the core and sorts it into one of three regions. The low sixteen addresses are special-function slots. The next sixteen form a common area that every bank sees. The upper thirty-two addresses form a window onto one of four banks. A pointer register at address 0x04 serves two purposes. Its low six bits are the target of an indirect access, and its top two bits pick the active bank. Address 0x00 has no storage of its own: any access to it is redirected to the address held in the pointer.

A separate 1 KB auxiliary RAM is never mapped directly into the register space. The core writes a byte index into the register at 0x0C and then moves data through 0x0D. The 256-byte bank of the auxiliary RAM is chosen by a 2-bit control input. All other special slots are passed to an external port, which carries an address, write data, a write strobe and returned read data.

Reads are combinational from the presented address. Writes take effect on the rising clock edge while the write enable is high.

Top module: `brf_top`

## Requirements
- R1: After reset, the pointer register (0x04) and the auxiliary address register (0x0C) both read 0x00.
- R2: Addresses 0x10–0x1F reach one 16-byte common area that returns the same contents whatever bank the pointer bits 7:6 select.
- R3: Addresses 0x20–0x3F reach a 32-byte window of bank number pointer[7:6] (0–3). A value written in one bank is not visible in another bank.
- R4: An access to address 0x00 behaves exactly like an access to the address in pointer[5:0], including the special slots, for both reads and writes.
- R5: An indirect access whose pointer[5:0] is 0x00 reads 0x00 and changes no storage and no register, and it raises no external strobe.
- R6: Address 0x04 reads back the last value written to it, and its value holds when it is not written.
- R7: Writing 0x0C sets the byte index. Address 0x0D reads and writes auxiliary byte {bank_sel, index}, where bank_sel is the 2-bit control input, so each of the four 256-byte banks is distinct.
- R8: Effective addresses 0x01–0x0F other than 0x04, 0x0C and 0x0D drive the external port: the address is the low 4 bits, the write data equals the core write data, the strobe follows the core write enable, and the read data is returned to the core. For every other address the strobe stays low.
- R9: With the write enable low, no location changes. Read data follows the address in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | 6 | Direct register address from the core |
| cpu_we | input | 1 | Write enable from the core |
| cpu_wdata | input | 8 | Write data from the core |
| cpu_rdata | output | 8 | Read data to the core |
| aux_bank_sel | input | 2 | Bank select for the auxiliary RAM |
| sfr_addr | output | 4 | External special-register address |
| sfr_we | output | 1 | External special-register write strobe |
| sfr_wdata | output | 8 | External special-register write data |
| sfr_rdata | input | 8 | External special-register read data |

## Verification
A corrupted pointer shows up on the very next read through 0x00 or the banked window. The read returns data from the wrong bank or offset in the same cycle the address is presented. The pointer also reads back wrongly at 0x04. A wrong auxiliary index or a wrong bank choice shows up as a stale or foreign byte at 0x0D on the first read after the faulty write. Mis-steering into the special slots shows up at once on the external strobe. A null indirect write that is not blocked shows up later, as a changed value at whichever location it struck.

// File: rtl/brf_pkg.sv
package brf_pkg;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 6;
  localparam int SFR_TOP  = 16;
  localparam int COMMON_TOP = 32;
  localparam logic [ADDR_W-1:0] A_PTR  = 6'h04;
  localparam logic [ADDR_W-1:0] A_AUXA = 6'h0C;
  localparam logic [ADDR_W-1:0] A_AUXD = 6'h0D;

  typedef enum logic [2:0] {
    RG_NULL, RG_SFR, RG_PTR, RG_AUXA, RG_AUXD, RG_COMMON, RG_BANKED
  } region_e;

  // Sort an effective address into its region
  function automatic region_e classify(input logic [ADDR_W-1:0] a);
    if (a == '0)                 return RG_NULL;
    else if (a == A_PTR)         return RG_PTR;
    else if (a == A_AUXA)        return RG_AUXA;
    else if (a == A_AUXD)        return RG_AUXD;
    else if (int'(a) < SFR_TOP)  return RG_SFR;
    else if (int'(a) < COMMON_TOP) return RG_COMMON;
    else                         return RG_BANKED;
  endfunction

  // Address seen after the indirection at address zero
  function automatic logic [ADDR_W-1:0] resolve(input logic [ADDR_W-1:0] a,
                                                input logic [ADDR_W-1:0] ptr_off);
    return (a == '0) ? ptr_off : a;
  endfunction
endpackage

// File: rtl/brf_resolver.sv
module brf_resolver
  import brf_pkg::*;
(
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [ADDR_W-1:0] ptr_off,
  output logic [ADDR_W-1:0] eff_addr,
  output region_e           region,
  output logic              indirect
);
  always_comb begin
    indirect = (cpu_addr == '0);
    eff_addr = resolve(cpu_addr, ptr_off);
    region   = classify(eff_addr);
  end
endmodule

// File: rtl/brf_gpr.sv
module brf_gpr #(
  parameter int DW     = 8,
  parameter int BANKS  = 4,
  parameter int COMMON = 16,
  parameter int WINDOW = 32
) (
  input  logic                       clk,
  input  logic                       we,
  input  logic                       common_sel,
  input  logic [$clog2(WINDOW)-1:0]  offset,
  input  logic [$clog2(BANKS)-1:0]   bank,
  input  logic [DW-1:0]              wdata,
  output logic [DW-1:0]              rdata
);
  localparam int CW = $clog2(COMMON);
  localparam int OW = $clog2(WINDOW);
  localparam int BW = $clog2(BANKS);

  logic [DW-1:0] common_mem [COMMON];
  logic [DW-1:0] bank_mem   [BANKS*WINDOW];

  logic [BW+OW-1:0] bidx;
  assign bidx = {bank, offset};

  always_ff @(posedge clk) begin
    if (we && common_sel)  common_mem[offset[CW-1:0]] <= wdata;
    if (we && !common_sel) bank_mem[bidx] <= wdata;
  end

  assign rdata = common_sel ? common_mem[offset[CW-1:0]] : bank_mem[bidx];
endmodule

// File: rtl/brf_aux.sv
module brf_aux #(
  parameter int DW    = 8,
  parameter int BANKS = 4,
  parameter int DEPTH = 256
) (
  input  logic                            clk,
  input  logic                            we,
  input  logic [$clog2(BANKS*DEPTH)-1:0]  idx,
  input  logic [DW-1:0]                   wdata,
  output logic [DW-1:0]                   rdata
);
  logic [DW-1:0] mem [BANKS*DEPTH];

  always_ff @(posedge clk)
    if (we) mem[idx] <= wdata;

  assign rdata = mem[idx];
endmodule

// File: rtl/brf_top.sv
module brf_top
  import brf_pkg::*;
#(
  parameter int GPR_BANKS = 4,
  parameter int AUX_BANKS = 4,
  parameter int AUX_DEPTH = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [5:0]        cpu_addr,
  input  logic              cpu_we,
  input  logic [7:0]        cpu_wdata,
  output logic [7:0]        cpu_rdata,
  input  logic [1:0]        aux_bank_sel,
  output logic [3:0]        sfr_addr,
  output logic              sfr_we,
  output logic [7:0]        sfr_wdata,
  input  logic [7:0]        sfr_rdata
);
  localparam int WINDOW = 64 - COMMON_TOP;
  localparam int COMMON = COMMON_TOP - SFR_TOP;
  localparam int GBW    = $clog2(GPR_BANKS);
  localparam int OW     = $clog2(WINDOW);
  localparam int AIW    = $clog2(AUX_DEPTH);
  localparam int ABW    = $clog2(AUX_BANKS);

  logic [7:0]        ptr_q, auxa_q;
  logic [ADDR_W-1:0] eff_addr;
  region_e           region;
  logic              indirect;
  logic              ptr_wr, auxa_wr, auxd_wr, gpr_wr;
  logic [7:0]        gpr_rdata, aux_rdata;

  brf_resolver u_res (
    .cpu_addr (cpu_addr),
    .ptr_off  (ptr_q[ADDR_W-1:0]),
    .eff_addr (eff_addr),
    .region   (region),
    .indirect (indirect)
  );

  assign ptr_wr  = cpu_we && (region == RG_PTR);
  assign auxa_wr = cpu_we && (region == RG_AUXA);
  assign auxd_wr = cpu_we && (region == RG_AUXD);
  assign gpr_wr  = cpu_we && (region == RG_COMMON || region == RG_BANKED);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      auxa_q <= '0;
    end else begin
      if (ptr_wr)  ptr_q  <= cpu_wdata;
      if (auxa_wr) auxa_q <= cpu_wdata;
    end
  end

  brf_gpr #(.DW(8), .BANKS(GPR_BANKS), .COMMON(COMMON), .WINDOW(WINDOW)) u_gpr (
    .clk        (clk),
    .we         (gpr_wr),
    .common_sel (region == RG_COMMON),
    .offset     (eff_addr[OW-1:0]),
    .bank       (ptr_q[7 -: GBW]),
    .wdata      (cpu_wdata),
    .rdata      (gpr_rdata)
  );

  brf_aux #(.DW(8), .BANKS(AUX_BANKS), .DEPTH(AUX_DEPTH)) u_aux (
    .clk   (clk),
    .we    (auxd_wr),
    .idx   ({aux_bank_sel[ABW-1:0], auxa_q[AIW-1:0]}),
    .wdata (cpu_wdata),
    .rdata (aux_rdata)
  );

  assign sfr_addr  = eff_addr[3:0];
  assign sfr_wdata = cpu_wdata;
  assign sfr_we    = cpu_we && (region == RG_SFR);

  always_comb begin
    unique case (region)
      RG_PTR:               cpu_rdata = ptr_q;
      RG_AUXA:              cpu_rdata = auxa_q;
      RG_AUXD:              cpu_rdata = aux_rdata;
      RG_SFR:               cpu_rdata = sfr_rdata;
      RG_COMMON, RG_BANKED: cpu_rdata = gpr_rdata;
      default:              cpu_rdata = '0;
    endcase
  end

  // Assertions
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (ptr_q == 8'h00 && auxa_q == 8'h00));
  p_null_only_indirect_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (region == RG_NULL) |-> indirect);
  p_null_reads_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (region == RG_NULL) |-> (cpu_rdata == 8'h00));
  p_null_no_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (region == RG_NULL) |-> !(gpr_wr || ptr_wr || auxa_wr || auxd_wr || sfr_we));
  p_ptr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ptr_wr |=> $stable(ptr_q));
  p_auxa_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !auxa_wr |=> $stable(auxa_q));
  p_sfr_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sfr_we |-> (cpu_we && sfr_addr != 4'h4 && sfr_addr != 4'hC && sfr_addr != 4'hD));
  p_single_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({gpr_wr, ptr_wr, auxa_wr, auxd_wr, sfr_we}) <= 1);
endmodule

// File: tb/brf_top_tb_top.sv
module brf_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] cpu_addr = '0;
  logic       cpu_we = 1'b0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  logic [1:0] aux_bank_sel = '0;
  logic [3:0] sfr_addr;
  logic       sfr_we;
  logic [7:0] sfr_wdata;
  logic [7:0] sfr_rdata = 8'hA5;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  brf_top dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_we(cpu_we),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .aux_bank_sel(aux_bank_sel),
    .sfr_addr(sfr_addr), .sfr_we(sfr_we), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata)
  );

  // {req, chk, addr, we, wdata, aux_bank, expected read}
  typedef struct packed {
    logic [3:0] req;
    logic       chk;
    logic [5:0] addr;
    logic       we;
    logic [7:0] wd;
    logic [1:0] ab;
    logic [7:0] exp;
  } vec_t;

  localparam int NV = 32;
  localparam vec_t VEC [NV] = '{
    '{4'd1, 1'b1, 6'h04, 1'b0, 8'h00, 2'd0, 8'h00}, // R1 pointer cleared
    '{4'd1, 1'b1, 6'h0C, 1'b0, 8'h00, 2'd0, 8'h00}, // R1 aux index cleared
    '{4'd6, 1'b0, 6'h04, 1'b1, 8'h20, 2'd0, 8'h00}, // R6 ptr = bank0/off 0x20
    '{4'd6, 1'b1, 6'h04, 1'b0, 8'h00, 2'd0, 8'h20}, // R6 readback
    '{4'd3, 1'b0, 6'h20, 1'b1, 8'h11, 2'd0, 8'h00}, // R3 bank0[0]
    '{4'd2, 1'b0, 6'h10, 1'b1, 8'h77, 2'd0, 8'h00}, // R2 common
    '{4'd6, 1'b0, 6'h04, 1'b1, 8'h60, 2'd0, 8'h00}, // R6 ptr = bank1/off 0x20
    '{4'd3, 1'b0, 6'h20, 1'b1, 8'h22, 2'd0, 8'h00}, // R3 bank1[0]
    '{4'd4, 1'b1, 6'h00, 1'b0, 8'h00, 2'd0, 8'h22}, // R4 indirect read
    '{4'd4, 1'b0, 6'h00, 1'b1, 8'h33, 2'd0, 8'h00}, // R4 indirect write
    '{4'd4, 1'b1, 6'h20, 1'b0, 8'h00, 2'd0, 8'h33}, // R4 landed in bank1
    '{4'd2, 1'b1, 6'h10, 1'b0, 8'h00, 2'd0, 8'h77}, // R2 common seen from bank1
    '{4'd6, 1'b0, 6'h04, 1'b1, 8'h20, 2'd0, 8'h00}, // back to bank0
    '{4'd3, 1'b1, 6'h20, 1'b0, 8'h00, 2'd0, 8'h11}, // R3 bank0 kept its byte
    '{4'd4, 1'b1, 6'h00, 1'b0, 8'h00, 2'd0, 8'h11}, // R4 indirect bank0
    '{4'd6, 1'b0, 6'h04, 1'b1, 8'hC0, 2'd0, 8'h00}, // ptr = bank3/off 0
    '{4'd5, 1'b0, 6'h00, 1'b1, 8'h55, 2'd0, 8'h00}, // R5 null write
    '{4'd5, 1'b1, 6'h00, 1'b0, 8'h00, 2'd0, 8'h00}, // R5 null reads zero
    '{4'd5, 1'b1, 6'h04, 1'b0, 8'h00, 2'd0, 8'hC0}, // R5 pointer untouched
    '{4'd7, 1'b0, 6'h0C, 1'b1, 8'h5A, 2'd2, 8'h00}, // R7 index 0x5A
    '{4'd7, 1'b0, 6'h0D, 1'b1, 8'h9C, 2'd2, 8'h00}, // R7 bank2 write
    '{4'd7, 1'b1, 6'h0D, 1'b0, 8'h00, 2'd2, 8'h9C}, // R7 bank2 read
    '{4'd7, 1'b0, 6'h0D, 1'b1, 8'h3E, 2'd1, 8'h00}, // R7 bank1 write
    '{4'd7, 1'b1, 6'h0D, 1'b0, 8'h00, 2'd2, 8'h9C}, // R7 bank2 unchanged
    '{4'd7, 1'b1, 6'h0D, 1'b0, 8'h00, 2'd1, 8'h3E}, // R7 bank1 read
    '{4'd7, 1'b1, 6'h0C, 1'b0, 8'h00, 2'd0, 8'h5A}, // R7 index readback
    '{4'd8, 1'b1, 6'h05, 1'b0, 8'h00, 2'd0, 8'hA5}, // R8 external read
    '{4'd9, 1'b1, 6'h10, 1'b0, 8'hFF, 2'd0, 8'h77}, // R9 no write with we low
    '{4'd9, 1'b1, 6'h10, 1'b0, 8'h00, 2'd0, 8'h77}, // R9 still 0x77
    '{4'd4, 1'b0, 6'h04, 1'b1, 8'h0C, 2'd0, 8'h00}, // ptr -> aux index slot
    '{4'd4, 1'b0, 6'h00, 1'b1, 8'h12, 2'd0, 8'h00}, // R4 indirect into 0x0C
    '{4'd4, 1'b1, 6'h0C, 1'b0, 8'h00, 2'd0, 8'h12}  // R4 index became 0x12
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [5:0] a, input logic w, input logic [7:0] d,
                       input logic [1:0] ab);
    @(negedge clk);
    cpu_addr = a; cpu_we = w; cpu_wdata = d; aux_bank_sel = ab;
    #2;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].addr, VEC[i].we, VEC[i].wd, VEC[i].ab);
      if (VEC[i].chk)
        check($sformatf("R%0d vec%0d", VEC[i].req, i), cpu_rdata, VEC[i].exp);
    end

    // R8 external strobe and fields for a forwarded write
    drive(6'h07, 1'b1, 8'h3C, 2'd0);
    check("R8 strobe", {7'd0, sfr_we}, 8'h01);
    check("R8 addr", {4'd0, sfr_addr}, 8'h07);
    check("R8 wdata", sfr_wdata, 8'h3C);
    // R8 strobe stays low for an owned slot and for storage
    drive(6'h0D, 1'b1, 8'h44, 2'd3);
    check("R8 no strobe at 0x0D", {7'd0, sfr_we}, 8'h00);
    drive(6'h30, 1'b1, 8'h66, 2'd0);
    check("R8 no strobe at 0x30", {7'd0, sfr_we}, 8'h00);
    // R8 forwarded through indirection (R4): ptr low bits = 0x09
    drive(6'h04, 1'b1, 8'h09, 2'd0);
    drive(6'h00, 1'b1, 8'h81, 2'd0);
    check("R4 indirect strobe", {7'd0, sfr_we}, 8'h01);
    check("R4 indirect addr", {4'd0, sfr_addr}, 8'h09);
    // R5 null indirect raises no strobe (ptr bank2, offset 0)
    drive(6'h04, 1'b1, 8'h80, 2'd0);
    drive(6'h00, 1'b1, 8'hEE, 2'd0);
    check("R5 null strobe", {7'd0, sfr_we}, 8'h00);
    drive(6'h04, 1'b0, 8'h00, 2'd0);
    check("R5 pointer after null write", cpu_rdata, 8'h80);

    // R1 mid-run reset clears pointer and aux index
    drive(6'h0C, 1'b1, 8'h77, 2'd0);
    drive(6'h04, 1'b0, 8'h00, 2'd0);
    rst_n = 1'b0;
    #2;
    check("R1 pointer after reset", cpu_rdata, 8'h00);
    cpu_addr = 6'h0C;
    #2;
    check("R1 aux index after reset", cpu_rdata, 8'h00);
    @(negedge clk) rst_n = 1'b1;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule